// File: doc/BRIEF.md
# Low-Confidence Fetch Gate

This block sits next to the front end of a speculative core and holds instruction fetch while too many weakly predicted branches are still in flight. Each time decode sees a branch that the confidence estimator marked as low confidence, an occupancy count goes up. When such a branch resolves in execute or commit, the count goes down. While the count is above a programmable limit, the block raises a fetch-stall request. This keeps likely wrong-path work out of the pipeline.

The gate only shapes throughput. It never decides architectural results, and it may be disabled by setting the limit to its largest value. A pipeline flush discards all speculative branches, so it empties the count.

Top module: `fetch_gate`

## Requirements
- R1: After reset (rst_ni low) the count is 0, stall_o is 0 and the limit is 2.
- R2: A decoded branch with dec_valid_i=1 and dec_lowconf_i=1 raises count_o by one in the next cycle.
- R3: A resolved branch with res_valid_i=1 and res_lowconf_i=1 lowers count_o by one in the next cycle.
- R4: A branch with its confidence input at 0 (high confidence) leaves count_o unchanged, both at decode and at resolve.
- R5: A low-confidence increment and decrement in the same cycle leave count_o unchanged.
- R6: count_o saturates: increments at 2^CNT_W-1 (7 by default) and decrements at 0 leave it unchanged.
- R7: flush_i=1 sets count_o to 0 in the next cycle, taking priority over any increment or decrement in that cycle.
- R8: stall_o is registered: in each cycle it equals (count_o > limit) as both stood in the previous cycle.
- R9: thr_wr_i=1 loads thr_data_i into the limit in the next cycle. With the limit at 7, stall_o never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A branch passed decode this cycle |
| dec_lowconf_i | input | 1 | That branch is low confidence |
| res_valid_i | input | 1 | A branch resolved this cycle |
| res_lowconf_i | input | 1 | The resolved branch was low confidence |
| flush_i | input | 1 | Pipeline flush, empties the count |
| thr_wr_i | input | 1 | Load a new limit |
| thr_data_i | input | CNT_W | New limit value |
| count_o | output | CNT_W | Unresolved low-confidence branches |
| stall_o | output | 1 | Fetch-stall request |

## Verification
The bench applies separate bursts of low-confidence decodes and resolves, and watches the count climb and fall across the limit. This shows that the stall rises and falls one cycle after the count crosses it. Overlapping decode and resolve pulses, and pulses on high-confidence branches, show that no net change occurs. Runs past the top and below zero check saturation. Flushes mixed with traffic, and limits of 0 and 7, show that flush takes priority and that the limit controls the stall.

// File: rtl/fetch_gate_pkg.sv
package fetch_gate_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/fg_op_decode.sv
module fg_op_decode
  import fetch_gate_pkg::*;
(
  input  logic    dec_valid_i,
  input  logic    dec_lowconf_i,
  input  logic    res_valid_i,
  input  logic    res_lowconf_i,
  input  logic    flush_i,
  output cnt_op_e op_o
);
  logic inc, dec;
  assign inc = dec_valid_i & dec_lowconf_i;
  assign dec = res_valid_i & res_lowconf_i;

  always_comb begin
    if (flush_i)          op_o = CNT_CLR;
    else if (inc && !dec) op_o = CNT_INC;
    else if (dec && !inc) op_o = CNT_DEC;
    else                  op_o = CNT_HOLD;
  end
endmodule

// File: rtl/fg_conf_counter.sv
module fg_conf_counter
  import fetch_gate_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (op_i)
        CNT_CLR:  cnt_q <= '0;
        CNT_INC:  if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
        CNT_DEC:  if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  // R6
  sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_INC && cnt_q == CntMax) |=> cnt_q == CntMax);
  // R6
  sat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_DEC && cnt_q == '0) |=> cnt_q == '0);
  // R7
  flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == CNT_CLR |=> cnt_q == '0);
endmodule

// File: rtl/fg_thresh_reg.sv
module fg_thresh_reg #(
  parameter int              CNT_W   = 3,
  parameter logic [CNT_W-1:0] THR_RST = 3'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_o <= THR_RST;
    else if (wr_i) thr_o <= data_i;
  end

  // R9
  thr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> thr_o == $past(data_i));
  // R9
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(thr_o));
endmodule

// File: rtl/fg_stall_cmp.sv
module fg_stall_cmp #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             stall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_o <= 1'b0;
    else         stall_o <= (cnt_i > thr_i);
  end

  // R8
  stall_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i > thr_i) |=> stall_o);
  // R8
  stall_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= thr_i) |=> !stall_o);
endmodule

// File: rtl/fetch_gate.sv
module fetch_gate
  import fetch_gate_pkg::*;
#(
  parameter int               CNT_W   = 3,
  parameter logic [CNT_W-1:0] THR_RST = 3'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic             dec_lowconf_i,
  input  logic             res_valid_i,
  input  logic             res_lowconf_i,
  input  logic             flush_i,
  input  logic             thr_wr_i,
  input  logic [CNT_W-1:0] thr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             stall_o
);
  cnt_op_e          op;
  logic [CNT_W-1:0] thr;

  fg_op_decode u_op (
    .dec_valid_i  (dec_valid_i),
    .dec_lowconf_i(dec_lowconf_i),
    .res_valid_i  (res_valid_i),
    .res_lowconf_i(res_lowconf_i),
    .flush_i      (flush_i),
    .op_o         (op)
  );

  fg_conf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .cnt_o (count_o)
  );

  fg_thresh_reg #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_thr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (thr_wr_i),
    .data_i(thr_data_i),
    .thr_o (thr)
  );

  fg_stall_cmp #(.CNT_W(CNT_W)) u_stall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (count_o),
    .thr_i  (thr),
    .stall_o(stall_o)
  );

  // R4
  hiconf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !(dec_valid_i && dec_lowconf_i) && !(res_valid_i && res_lowconf_i))
      |=> $stable(count_o));
  // R5
  inc_dec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && dec_valid_i && dec_lowconf_i && res_valid_i && res_lowconf_i)
      |=> $stable(count_o));
  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && dec_valid_i && dec_lowconf_i && !res_valid_i && count_o != {CNT_W{1'b1}})
      |=> count_o == $past(count_o) + 1'b1);
  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && res_valid_i && res_lowconf_i && !dec_valid_i && count_o != '0)
      |=> count_o == $past(count_o) - 1'b1);
endmodule

// File: tb/fetch_gate_tb_top.sv
module fetch_gate_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dec_valid_i = 0, dec_lowconf_i = 0;
  logic       res_valid_i = 0, res_lowconf_i = 0;
  logic       flush_i = 0, thr_wr_i = 0;
  logic [2:0] thr_data_i = '0;
  logic [2:0] count_o;
  logic       stall_o;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_thr = 2, m_stall = 0;

  always #2.5 clk_i = ~clk_i;

  fetch_gate dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dec_valid_i(dec_valid_i), .dec_lowconf_i(dec_lowconf_i),
    .res_valid_i(res_valid_i), .res_lowconf_i(res_lowconf_i),
    .flush_i(flush_i), .thr_wr_i(thr_wr_i), .thr_data_i(thr_data_i),
    .count_o(count_o), .stall_o(stall_o)
  );

  task automatic check(string req);
    n_chk++;
    if (int'(count_o) != m_cnt || int'(stall_o) != m_stall) begin
      n_fail++;
      $display("FAIL %s: count=%0d stall=%0d expected count=%0d stall=%0d",
               req, count_o, stall_o, m_cnt, m_stall);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(string req, bit dv, bit dl, bit rv, bit rl,
                      bit fl = 0, bit tw = 0, int td = 0);
    bit inc, dec;
    dec_valid_i = dv; dec_lowconf_i = dl;
    res_valid_i = rv; res_lowconf_i = rl;
    flush_i = fl; thr_wr_i = tw; thr_data_i = 3'(td);
    @(posedge clk_i);
    m_stall = (m_cnt > m_thr);
    inc = dv && dl; dec = rv && rl;
    if (fl) m_cnt = 0;
    else if (inc && !dec && m_cnt < 7) m_cnt++;
    else if (dec && !inc && m_cnt > 0) m_cnt--;
    if (tw) m_thr = td;
    @(negedge clk_i);
    check(req);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1");
    // R2 / R8: climb past limit 2
    for (int i = 0; i < 4; i++) step("R2", 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0);
    // R4: high-confidence traffic
    step("R4", 1, 0, 0, 0);
    step("R4", 0, 0, 1, 0);
    step("R4", 1, 0, 1, 0);
    // R5: overlapping low-confidence pulses
    step("R5", 1, 1, 1, 1);
    step("R5", 1, 1, 1, 0);
    // R3 / R8: fall back under
    for (int i = 0; i < 3; i++) step("R3", 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0);
    // R6: saturation
    for (int i = 0; i < 9; i++) step("R6", 1, 1, 0, 0);
    for (int i = 0; i < 9; i++) step("R6", 0, 0, 1, 1);
    // R7: flush priority
    for (int i = 0; i < 5; i++) step("R2", 1, 1, 0, 0);
    step("R7", 1, 1, 0, 0, 1);
    step("R7", 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R2", 1, 1, 0, 0);
    step("R7", 0, 0, 1, 1, 1);
    // R9: limit 0 then 7
    step("R9", 0, 0, 0, 0, 0, 1, 0);
    step("R9", 1, 1, 0, 0);
    step("R9", 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 7);
    for (int i = 0; i < 9; i++) step("R9", 1, 1, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 4);
    step("R8", 0, 0, 1, 1);
    step("R8", 0, 0, 1, 1);
    step("R8", 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0);
    // mixed pattern
    for (int i = 0; i < 40; i++)
      step("R8", (i % 3) != 0, (i % 2) == 0, (i % 4) == 1, (i % 5) != 2, i == 33);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule